// File: doc/BRIEF.md
# Claim-Line Bus Ownership Arbiter

This block lets one host win the right to drive a shared two-wire bus that several hosts can reach. Each host owns one active-low claim line and can see the lines of all the others. Contention is settled out of band, on those lines, rather than by bit-level arbitration on the bus itself. Local logic raises an acquire request. The block then drives its own claim low and waits a settle time so the other hosts can see the edge. After that it looks at the foreign claim lines.

If no foreign line is low, the bus is granted. If a foreign line is low, the block keeps its claim and waits a bounded window for the line to clear. If the line stays low, the block drops its claim, waits a retry interval and starts again. A single give-up deadline, measured from the moment the request is accepted, bounds the whole attempt. When the deadline passes, the attempt ends with a one-cycle timeout pulse.

All delays are given in microseconds on configuration inputs. A prescaler derives a 1 µs tick from the system clock frequency parameter, and every delay counter counts that tick.

Top module: `claim_arbiter`

## Requirements
- R1: After reset, and whenever the block is neither busy nor granted, `claim_n` is 1. After reset `granted`, `busy` and `timeout` are all 0.
- R2: An `acq_req` seen while idle drives `claim_n` to 0 and `busy` to 1 from the next cycle on.
- R3: After the claim is driven, no grant is given until more than `cfg_settle_us` microseconds have passed. `claim_n` stays 0 during this settle time.
- R4: When the settle time ends and every synchronized foreign line reads 1, `granted` becomes 1. `claim_n` stays 0 for as long as the grant is held.
- R5: If a foreign line reads 0 after the settle time, `claim_n` stays 0 and the block waits up to `cfg_window_us`. If all foreign lines return to 1 inside that window, it grants.
- R6: If the window expires with a foreign line still at 0, `claim_n` goes to 1 for `cfg_retry_us`. The claim is then driven again and the sequence restarts with the settle time.
- R7: The give-up deadline `cfg_giveup_us` starts when the request is accepted and is not restarted by retries. Once it has passed, any busy phase ends in failure, and this takes priority over a grant.
- R8: A failure raises `timeout` for exactly one cycle, with `claim_n` at 1. The block then returns to idle and accepts a new request.
- R9: While granted, `rel_req` sets `claim_n` to 1 and `granted` to 0 on the next cycle. `rel_req` in any other state has no effect, and `acq_req` while not idle has no effect.
- R10: Each of the `N_FOREIGN` foreign lines passes through two flip-flops before it is used. A 0 on any one of them counts as contention.
- R11: A delay of D microseconds lasts more than D and at most D+1 microseconds of the prescaled tick. D = 0 therefore ends at the first tick.
- R12: At most one of `granted`, `busy` and `timeout` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | 1 | Request to acquire the bus (accepted while idle) |
| rel_req | input | 1 | Request to release a granted bus |
| foreign_claim_n | input | N_FOREIGN | Claim lines of the other hosts, active low, asynchronous |
| cfg_settle_us | input | TW | Settle time after driving the claim, in µs |
| cfg_window_us | input | TW | Longest wait for foreign claims to clear, in µs |
| cfg_retry_us | input | TW | Back-off time with the claim released, in µs |
| cfg_giveup_us | input | TW | Overall deadline for one acquire attempt, in µs |
| claim_n | output | 1 | This host's claim line, active low |
| granted | output | 1 | Bus is owned by this host |
| busy | output | 1 | Acquire attempt in progress |
| timeout | output | 1 | One-cycle pulse when an attempt gives up |

## Verification
The assertions check the following on every cycle: status exclusivity, the claim level that goes with each status, the one-cycle timeout shape, and the one-cycle responses to acquire and release. They also check that a grant only follows a cycle in which every synchronized foreign line read high after a held claim. Only the bench's timed scenarios can show the microsecond durations: the settle lower bound, the length of the window and the back-off, and a give-up deadline that survives several retries. The same holds for the priority of the deadline over a clean grant. Each scenario predicts a grant or timeout latency range from the configured delays, and a scoreboard compares it against the event the block produces.

// File: rtl/claim_arb_pkg.sv
package claim_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CHECK,
        ST_WAIT_FREE,
        ST_BACKOFF,
        ST_GRANTED,
        ST_FAIL
    } arb_state_e;

    typedef struct packed {
        logic claim_n;
        logic granted;
        logic busy;
        logic timeout;
    } arb_out_s;

    function automatic int unsigned cycles_per_us(input int unsigned hz);
        return (hz / 1000000 < 1) ? 1 : hz / 1000000;
    endfunction

    function automatic arb_out_s decode_outputs(input arb_state_e s);
        arb_out_s o;
        o.claim_n = 1'b1;
        o.granted = 1'b0;
        o.busy    = 1'b0;
        o.timeout = 1'b0;
        case (s)
            ST_SETTLE, ST_CHECK, ST_WAIT_FREE: begin
                o.claim_n = 1'b0;
                o.busy    = 1'b1;
            end
            ST_BACKOFF: o.busy = 1'b1;
            ST_GRANTED: begin
                o.claim_n = 1'b0;
                o.granted = 1'b1;
            end
            ST_FAIL: o.timeout = 1'b1;
            default: ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/claim_sync.sv
module claim_sync #(
    parameter int N_LINES = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] line_n_async,
    output logic [N_LINES-1:0] line_n_sync
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], line_n_async[i]};
        end
        assign line_n_sync[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/us_ticker.sv
module us_ticker #(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    import claim_arb_pkg::*;
    localparam int unsigned DIV = cycles_per_us(CLK_HZ);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/us_timer.sv
module us_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          en,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          done
);
    logic [TW:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst || clear)
            elapsed <= '0;
        else if (en && tick && !elapsed[TW])
            elapsed <= elapsed + 1'b1;
    end

    assign done = (elapsed > {1'b0, limit});
endmodule

// File: rtl/claim_arbiter.sv
module claim_arbiter #(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int          N_FOREIGN = 2,
    parameter int          TW        = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acq_req,
    input  logic                 rel_req,
    input  logic [N_FOREIGN-1:0] foreign_claim_n,
    input  logic [TW-1:0]        cfg_settle_us,
    input  logic [TW-1:0]        cfg_window_us,
    input  logic [TW-1:0]        cfg_retry_us,
    input  logic [TW-1:0]        cfg_giveup_us,
    output logic                 claim_n,
    output logic                 granted,
    output logic                 busy,
    output logic                 timeout
);
    import claim_arb_pkg::*;

    arb_state_e           state_q, state_d;
    arb_out_s             outs;
    logic [N_FOREIGN-1:0] fc_sync;
    logic                 contention;
    logic                 us_tick;
    logic [TW-1:0]        phase_limit;
    logic                 phase_done;
    logic                 giveup_done;

    claim_sync #(.N_LINES(N_FOREIGN), .STAGES(2)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .line_n_async (foreign_claim_n),
        .line_n_sync  (fc_sync)
    );

    us_ticker #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (us_tick)
    );

    always_comb begin
        case (state_q)
            ST_SETTLE:    phase_limit = cfg_settle_us;
            ST_WAIT_FREE: phase_limit = cfg_window_us;
            ST_BACKOFF:   phase_limit = cfg_retry_us;
            default:      phase_limit = '0;
        endcase
    end

    us_timer #(.TW(TW)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .clear (state_d != state_q),
        .en    (1'b1),
        .tick  (us_tick),
        .limit (phase_limit),
        .done  (phase_done)
    );

    us_timer #(.TW(TW)) u_giveup (
        .clk   (clk),
        .rst   (rst),
        .clear (state_q == ST_IDLE),
        .en    (outs.busy),
        .tick  (us_tick),
        .limit (cfg_giveup_us),
        .done  (giveup_done)
    );

    assign contention = |(~fc_sync);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:
                if (acq_req) state_d = ST_SETTLE;
            ST_SETTLE:
                if (giveup_done)     state_d = ST_FAIL;
                else if (phase_done) state_d = ST_CHECK;
            ST_CHECK:
                if (giveup_done)     state_d = ST_FAIL;
                else if (contention) state_d = ST_WAIT_FREE;
                else                 state_d = ST_GRANTED;
            ST_WAIT_FREE:
                if (giveup_done)      state_d = ST_FAIL;
                else if (!contention) state_d = ST_GRANTED;
                else if (phase_done)  state_d = ST_BACKOFF;
            ST_BACKOFF:
                if (giveup_done)     state_d = ST_FAIL;
                else if (phase_done) state_d = ST_SETTLE;
            ST_GRANTED:
                if (rel_req) state_d = ST_IDLE;
            ST_FAIL:
                state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign outs    = decode_outputs(state_q);
    assign claim_n = outs.claim_n;
    assign granted = outs.granted;
    assign busy    = outs.busy;
    assign timeout = outs.timeout;
endmodule

// File: rtl/claim_arb_chk.sv
module claim_arb_chk #(
    parameter int N_FOREIGN = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 acq_req,
    input logic                 rel_req,
    input logic                 claim_n,
    input logic                 granted,
    input logic                 busy,
    input logic                 timeout,
    input logic [N_FOREIGN-1:0] fc_sync
);
    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
        $onehot0({granted, busy, timeout})) else $error("status overlap"); // R12

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!busy && !granted) |-> claim_n) else $error("claim held while idle"); // R1

    AST_ACQ_CLAIMS: assert property (@(posedge clk) disable iff (rst)
        (acq_req && !busy && !granted && !timeout) |=> (busy && !claim_n)) else $error("acquire not taken"); // R2

    AST_GRANT_AFTER_CLAIM: assert property (@(posedge clk) disable iff (rst)
        $rose(granted) |-> ($past(busy) && !$past(claim_n))) else $error("grant without held claim"); // R3

    AST_GRANT_DRIVES: assert property (@(posedge clk) disable iff (rst)
        granted |-> !claim_n) else $error("grant without claim"); // R4

    AST_GRANT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $rose(granted) |-> $past(&fc_sync)) else $error("grant under contention"); // R10

    AST_TIMEOUT_RELEASED: assert property (@(posedge clk) disable iff (rst)
        timeout |-> claim_n) else $error("claim held on timeout"); // R8

    AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (rst)
        timeout |=> (!timeout && !busy && !granted)) else $error("timeout not a pulse"); // R8

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (granted && rel_req) |=> (claim_n && !granted)) else $error("release ignored"); // R9
endmodule

bind claim_arbiter claim_arb_chk #(.N_FOREIGN(N_FOREIGN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .acq_req (acq_req),
    .rel_req (rel_req),
    .claim_n (claim_n),
    .granted (granted),
    .busy    (busy),
    .timeout (timeout),
    .fc_sync (fc_sync)
);

// File: tb/tb_claim_arbiter.sv
module tb_claim_arbiter;
    localparam int TW = 16;
    localparam int NF = 2;
    localparam int US = 50;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acq_req = 1'b0;
    logic          rel_req = 1'b0;
    logic [NF-1:0] fc_n = '1;
    logic [TW-1:0] settle = 16'd4, window = 16'd20, retry = 16'd30, giveup = 16'd1000;
    logic          claim_n, granted, busy, timeout;

    claim_arbiter #(.CLK_HZ(50_000_000), .N_FOREIGN(NF), .TW(TW)) dut (
        .clk(clk), .rst(rst), .acq_req(acq_req), .rel_req(rel_req),
        .foreign_claim_n(fc_n), .cfg_settle_us(settle), .cfg_window_us(window),
        .cfg_retry_us(retry), .cfg_giveup_us(giveup),
        .claim_n(claim_n), .granted(granted), .busy(busy), .timeout(timeout)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int t0 = 0;
    bit done_flag = 0;

    // scoreboard: expected events (0 = grant, 1 = timeout) with latency window
    int    exp_kind[$];
    int    exp_lo[$];
    int    exp_hi[$];
    string exp_req[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_evt(input int kind, input int lo, input int hi, input string req);
        exp_kind.push_back(kind);
        exp_lo.push_back(lo);
        exp_hi.push_back(hi);
        exp_req.push_back(req);
    endtask

    task automatic pulse_acq();
        @(negedge clk);
        t0 = cyc;
        acq_req = 1'b1;
        @(negedge clk);
        acq_req = 1'b0;
    endtask

    task automatic pulse_rel();
        @(negedge clk);
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
    endtask

    task automatic drain();
        while (exp_kind.size() != 0) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done_flag) begin
            failures++;
            checks++;
            $display("FAIL R7 watchdog expired actual=%0d expected<%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // monitor: pops expected events as the design produces them
    bit g_prev = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if ((granted && !g_prev) || timeout) begin
                int kind;
                kind = timeout ? 1 : 0;
                if (exp_kind.size() == 0) begin
                    chk(0, "R12", "unexpected event kind", kind, -1);
                end else begin
                    int k, lo, hi, lat;
                    string rq;
                    k = exp_kind.pop_front();
                    lo = exp_lo.pop_front();
                    hi = exp_hi.pop_front();
                    rq = exp_req.pop_front();
                    lat = cyc - t0;
                    chk(kind == k, rq, "event kind", kind, k);
                    chk(lat >= lo && lat <= hi, rq, "event latency", lat, lo);
                end
            end
        end
        g_prev = granted;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(claim_n == 1'b1, "R1", "claim_n after reset", claim_n, 1);
        chk(granted == 1'b0, "R1", "granted after reset", granted, 0);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(timeout == 1'b0, "R1", "timeout after reset", timeout, 0);

        // R2/R3/R4 uncontested acquire, settle 4 us
        expect_evt(0, 4*US, 5*US+5, "R4");
        pulse_acq();
        chk(claim_n == 1'b0, "R2", "claim_n after acquire", claim_n, 0);
        chk(busy == 1'b1, "R2", "busy after acquire", busy, 1);
        repeat (3*US) @(negedge clk);
        chk(!granted && !claim_n, "R3", "no grant during settle", granted, 0);
        drain();
        chk(claim_n == 1'b0, "R4", "claim held while granted", claim_n, 0);

        // R9 acquire while granted ignored, release, release in idle ignored
        pulse_acq();
        repeat (3) @(negedge clk);
        chk(granted && !claim_n, "R9", "acquire while granted ignored", granted, 1);
        pulse_rel();
        chk(claim_n && !granted, "R9", "release drops claim", claim_n, 1);
        pulse_rel();
        repeat (2) @(negedge clk);
        chk(claim_n && !granted && !busy, "R9", "release in idle ignored", claim_n, 1);

        // R5/R10 second line contends, clears inside window
        fc_n = 2'b01;
        repeat (5) @(negedge clk);
        expect_evt(0, 10*US, 10*US+10, "R5");
        pulse_acq();
        repeat (10*US - 2) @(negedge clk);
        chk(!granted && !claim_n && busy, "R5", "claim held while contended", claim_n, 0);
        fc_n = 2'b11;
        drain();
        pulse_rel();

        // R6 first line contends past window, clears during back-off
        fc_n = 2'b10;
        repeat (5) @(negedge clk);
        expect_evt(0, 58*US, 63*US, "R6");
        pulse_acq();
        while (!claim_n) @(negedge clk);
        chk((cyc - t0) >= 24*US && (cyc - t0) <= 26*US+10, "R6", "back-off start", cyc - t0, 24*US);
        fc_n = 2'b11;
        begin
            int tb;
            tb = cyc;
            while (claim_n) @(negedge clk);
            chk((cyc - tb) >= 30*US && (cyc - tb) <= 31*US+5, "R6", "back-off length", cyc - tb, 30*US);
        end
        drain();
        pulse_rel();

        // R7/R8 permanent contention, give-up 200 us spans several retries
        fc_n = 2'b00;
        giveup = 16'd200;
        repeat (5) @(negedge clk);
        expect_evt(1, 200*US, 201*US+10, "R7");
        begin
            int falls;
            bit cprev;
            falls = 0;
            pulse_acq();
            cprev = 1'b0;
            falls = 1;
            while (exp_kind.size() != 0) begin
                @(negedge clk);
                if (cprev && !claim_n) falls++;
                cprev = claim_n;
            end
            chk(falls >= 3, "R7", "claims driven before give-up", falls, 3);
        end
        @(negedge clk);
        chk(!timeout && claim_n && !busy && !granted, "R8", "idle after timeout pulse", timeout, 0);

        // R7 give-up shorter than settle wins over clean grant
        fc_n = 2'b11;
        giveup = 16'd3;
        repeat (5) @(negedge clk);
        expect_evt(1, 3*US, 4*US+10, "R7");
        pulse_acq();
        drain();
        @(negedge clk);
        chk(!granted && claim_n, "R7", "no grant after give-up", granted, 0);

        // R11/R8 zero settle, new request accepted after failure
        giveup = 16'd1000;
        settle = 16'd0;
        expect_evt(0, 1, 1*US+5, "R11");
        pulse_acq();
        drain();
        chk(granted == 1'b1, "R11", "grant with zero settle", granted, 1);
        pulse_rel();

        repeat (5) @(negedge clk);
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule